// File: doc/BRIEF.md
# Burst Bus Master Sequencer

This block is the master end of a synchronous external bus. An internal requester presents one request through a valid/ready handshake. The request carries a start address, a direction, a burst-or-single choice, a four-bit attribute code and the write data for every beat. The sequencer drives a one-cycle address phase and then steps through the data beats. Each slave acknowledge completes one beat. While more beats of a burst remain, the sequencer holds a continuation strobe high.

When the slave marks the first beat of a burst as not burstable, the sequencer finishes the rest of the burst as separate single transfers. Each of these has its own address phase, and the address steps forward one word at a time. A transfer error ends the request at once. The requester receives read data beat by beat, a done pulse, and an error flag that rises together with that pulse.

A reservation strobe is decoded from the attribute code. It is driven low for the whole of a transfer whose attribute marks a core data reservation.

Top module: `bbm_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high, and the address phase appears in the following cycle.
- R2: The address phase lasts exactly one cycle, with `bus_ts` high. `bus_burst` is high for a burst request until fallback, and is low for single transfers. `bus_ts` is low during data cycles.
- R3: `bus_rsv_n` is low during a transfer only when attribute bit 0 = 0, bit 2 = 1 and bit 3 = 0. Bit 1 does not matter. In every other case, including idle, it is high.
- R4: `bus_bdip` is high in a data cycle of a burst (4 beats) only when another beat follows the current one. It is low on the last beat and low in all single transfers.
- R5: Each acknowledge sampled without an error completes exactly one beat. On a read, `rsp_rvalid` pulses with that beat's `bus_rdata` on `rsp_rdata` in the cycle after the acknowledge.
- R6: If burst inhibit is sampled with the first beat's acknowledge of a burst, that beat counts as done. Each remaining beat k (k = 1..3) then runs as a single transfer with its own address phase at start address + 4·k.
- R7: Burst inhibit has no effect on a single request, or on beats after the first one of a burst.
- R8: An error sampled in a data cycle ends the request immediately, even if an acknowledge arrives in the same cycle. In the next cycle `rsp_done` and `rsp_err` are high, `rsp_rvalid` is low, the sequencer is idle, and any remaining beats are dropped.
- R9: `bus_addr` and `bus_wdata` stay constant through wait cycles until the beat ends with an acknowledge or an error. In burst mode the address stays at the start address.
- R10: `rsp_done` pulses for one cycle, in the cycle after the final beat's acknowledge, with `rsp_err` low. `rsp_err` is never high without `rsp_done`.
- R11: During beat k of a write, `bus_wdata` carries `req_wdata[32k+31:32k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single |
| req_addr | input | 32 | Start byte address |
| req_attr | input | 4 | Attribute code |
| req_wdata | input | 128 | Write data, beat k in bits 32k+31:32k |
| rsp_done | output | 1 | Request finished (one-cycle pulse) |
| rsp_err | output | 1 | Request ended by a transfer error |
| rsp_rvalid | output | 1 | Read beat available |
| rsp_rdata | output | 32 | Read beat data |
| bus_ts | output | 1 | Address phase strobe |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | Bus direction, high for write |
| bus_burst | output | 1 | Burst transfer flag |
| bus_bdip | output | 1 | Another beat follows the current one |
| bus_rsv_n | output | 1 | Reservation strobe, active low |
| bus_wdata | output | 32 | Write data of the current beat |
| bus_rdata | input | 32 | Read data from the slave |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_bi | input | 1 | Burst inhibit |
| bus_tea | input | 1 | Transfer error |

## Verification
A beat counter that is off by one shows up at the ports right away. It puts a wrong continuation strobe or a wrong write word on the very next beat, and in fallback it puts a wrong word address on the next address phase. A wrong mode or state bit is visible within one cycle of the next termination. It shows as an extra or missing address phase, a done pulse that comes early or late, read data that is dropped, or an error that does not end the request. The sweep runs every combination of direction, burst choice, burst-inhibit placement, error beat and wait count, and it checks the bus and the response outputs on every cycle of every transfer.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bbm_state_e;

  // attribute bit positions used by the reservation decode
  localparam int unsigned ATTR_CORE_BIT = 0;  // 0 = core access
  localparam int unsigned ATTR_DATA_BIT = 2;  // 1 = data
  localparam int unsigned ATTR_RSV_BIT  = 3;  // 0 = reservation

endpackage

// File: rtl/bbm_rsv_dec.sv
module bbm_rsv_dec
  import bbm_pkg::*;
#(
  parameter int unsigned ATTR_W = 4
) (
  input  logic              active,
  input  logic [ATTR_W-1:0] attr,
  output logic              rsv_n
);

  localparam logic [ATTR_W-1:0] MASK  = ATTR_W'((1 << ATTR_CORE_BIT) |
                                                (1 << ATTR_DATA_BIT) |
                                                (1 << ATTR_RSV_BIT));
  localparam logic [ATTR_W-1:0] MATCH = ATTR_W'(1 << ATTR_DATA_BIT);

  always_comb begin
    rsv_n = !(active && ((attr & MASK) == MATCH));
  end

endmodule

// File: rtl/bbm_beat_ctl.sv
module bbm_beat_ctl #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned ATTR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                ld_write,
  input  logic                ld_burst,
  input  logic [AW-1:0]       ld_addr,
  input  logic [ATTR_W-1:0]   ld_attr,
  input  logic [BEATS*DW-1:0] ld_wdata,
  input  logic                beat_adv,
  input  logic                fall_back,
  output logic                burst_mode,
  output logic                write,
  output logic [ATTR_W-1:0]   attr,
  output logic [AW-1:0]       addr,
  output logic [DW-1:0]       wdata,
  output logic                first_beat,
  output logic                last_beat
);

  localparam int unsigned BW   = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int unsigned SH   = $clog2(DW / 8);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic [AW-1:0]       base_q,  base_d;
  logic [BEATS*DW-1:0] wbuf_q,  wbuf_d;
  logic [ATTR_W-1:0]   attr_q,  attr_d;
  logic                write_q, write_d;
  logic                breq_q,  breq_d;
  logic                mode_q,  mode_d;
  logic [BW-1:0]       beat_q,  beat_d;

  // next-state
  always_comb begin
    base_d  = base_q;
    wbuf_d  = wbuf_q;
    attr_d  = attr_q;
    write_d = write_q;
    breq_d  = breq_q;
    mode_d  = mode_q;
    beat_d  = beat_q;
    if (load) begin
      base_d  = ld_addr;
      wbuf_d  = ld_wdata;
      attr_d  = ld_attr;
      write_d = ld_write;
      breq_d  = ld_burst;
      mode_d  = ld_burst;
      beat_d  = '0;
    end else begin
      if (beat_adv)  beat_d = beat_q + 1'b1;
      if (fall_back) mode_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      wbuf_q  <= '0;
      attr_q  <= '0;
      write_q <= 1'b0;
      breq_q  <= 1'b0;
      mode_q  <= 1'b0;
      beat_q  <= '0;
    end else begin
      base_q  <= base_d;
      wbuf_q  <= wbuf_d;
      attr_q  <= attr_d;
      write_q <= write_d;
      breq_q  <= breq_d;
      mode_q  <= mode_d;
      beat_q  <= beat_d;
    end
  end

  always_comb begin
    burst_mode = mode_q;
    write      = write_q;
    attr       = attr_q;
    addr       = base_q + (mode_q ? '0 : (AW'(beat_q) << SH));
    wdata      = wbuf_q[int'(beat_q)*DW +: DW];
    first_beat = (beat_q == '0);
    last_beat  = !breq_q || (beat_q == LAST);
  end

  // R5: the controller never steps past the final beat
  p_adv_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv |-> !last_beat);

  // R6: fallback only from the first beat of an active burst
  p_fallback_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_back |-> (first_beat && burst_mode));

endmodule

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          write,
  input  logic          burst_mode,
  input  logic          first_beat,
  input  logic          last_beat,
  input  logic          bus_ta,
  input  logic          bus_bi,
  input  logic          bus_tea,
  input  logic [DW-1:0] bus_rdata,
  output logic          req_ready,
  output logic          load,
  output logic          beat_adv,
  output logic          fall_back,
  output logic          bus_ts,
  output logic          bus_bdip,
  output logic          in_xfer,
  output logic          in_data,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic          rsp_rvalid,
  output logic [DW-1:0] rsp_rdata
);

  bbm_state_e    state_q, state_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          rvalid_q, rvalid_d;
  logic [DW-1:0] rdata_q, rdata_d;

  // next-state
  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    beat_adv  = 1'b0;
    fall_back = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    rvalid_d  = 1'b0;
    rdata_d   = rdata_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (bus_tea) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else if (bus_ta) begin
          if (!write) begin
            rvalid_d = 1'b1;
            rdata_d  = bus_rdata;
          end
          if (last_beat) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            beat_adv = 1'b1;
            if (!burst_mode) begin
              state_d = ST_ADDR;
            end else if (first_beat && bus_bi) begin
              fall_back = 1'b1;
              state_d   = ST_ADDR;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      err_q    <= err_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    bus_ts     = (state_q == ST_ADDR);
    in_data    = (state_q == ST_DATA);
    in_xfer    = (state_q != ST_IDLE);
    bus_bdip   = in_data && burst_mode && !last_beat;
    rsp_done   = done_q;
    rsp_err    = err_q;
    rsp_rvalid = rvalid_q;
    rsp_rdata  = rdata_q;
  end

  // R1: a taken request opens an address phase next cycle
  p_accept_ts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> bus_ts);

  // R2: address phase lasts one cycle and leads into data
  p_ts_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> (!bus_ts && in_data));

  // R8: error wins over acknowledge and closes the request
  p_tea_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && bus_tea) |=> (rsp_done && rsp_err && !rsp_rvalid && req_ready));

  // R10: error status only together with done
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

// File: rtl/bbm_seq.sv
module bbm_seq #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned ATTR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_burst,
  input  logic [AW-1:0]       req_addr,
  input  logic [ATTR_W-1:0]   req_attr,
  input  logic [BEATS*DW-1:0] req_wdata,
  output logic                rsp_done,
  output logic                rsp_err,
  output logic                rsp_rvalid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                bus_ts,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_write,
  output logic                bus_burst,
  output logic                bus_bdip,
  output logic                bus_rsv_n,
  output logic [DW-1:0]       bus_wdata,
  input  logic [DW-1:0]       bus_rdata,
  input  logic                bus_ta,
  input  logic                bus_bi,
  input  logic                bus_tea
);

  logic              load, beat_adv, fall_back;
  logic              burst_mode, write, first_beat, last_beat;
  logic              in_xfer, in_data;
  logic [ATTR_W-1:0] attr;

  bbm_beat_ctl #(
    .AW(AW), .DW(DW), .BEATS(BEATS), .ATTR_W(ATTR_W)
  ) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .ld_write   (req_write),
    .ld_burst   (req_burst),
    .ld_addr    (req_addr),
    .ld_attr    (req_attr),
    .ld_wdata   (req_wdata),
    .beat_adv   (beat_adv),
    .fall_back  (fall_back),
    .burst_mode (burst_mode),
    .write      (write),
    .attr       (attr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .first_beat (first_beat),
    .last_beat  (last_beat)
  );

  bbm_ctrl #(
    .DW(DW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .write      (write),
    .burst_mode (burst_mode),
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .bus_ta     (bus_ta),
    .bus_bi     (bus_bi),
    .bus_tea    (bus_tea),
    .bus_rdata  (bus_rdata),
    .req_ready  (req_ready),
    .load       (load),
    .beat_adv   (beat_adv),
    .fall_back  (fall_back),
    .bus_ts     (bus_ts),
    .bus_bdip   (bus_bdip),
    .in_xfer    (in_xfer),
    .in_data    (in_data),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .rsp_rvalid (rsp_rvalid),
    .rsp_rdata  (rsp_rdata)
  );

  bbm_rsv_dec #(
    .ATTR_W(ATTR_W)
  ) u_rsv (
    .active (in_xfer),
    .attr   (attr),
    .rsv_n  (bus_rsv_n)
  );

  always_comb begin
    bus_burst = in_xfer && burst_mode;
    bus_write = in_xfer && write;
  end

  // R9: address and write data held through wait cycles
  p_hold_in_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !bus_ta && !bus_tea) |=> ($stable(bus_addr) && $stable(bus_wdata)));

  // R3: no reservation outside a transfer
  p_rsv_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_rsv_n);

  // R4: continuation strobe only inside a burst
  p_bdip_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bdip |-> (bus_burst && !bus_ts));

endmodule

// File: tb/bbm_seq_tb.sv
`timescale 1ns/1ps
module bbm_seq_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_write, req_burst;
  logic [31:0]  req_addr;
  logic [3:0]   req_attr;
  logic [127:0] req_wdata;
  logic         rsp_done, rsp_err, rsp_rvalid;
  logic [31:0]  rsp_rdata;
  logic         bus_ts, bus_write, bus_burst, bus_bdip, bus_rsv_n;
  logic [31:0]  bus_addr, bus_wdata, bus_rdata;
  logic         bus_ta, bus_bi, bus_tea;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bbm_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_burst(req_burst), .req_addr(req_addr), .req_attr(req_attr),
    .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rvalid(rsp_rvalid),
    .rsp_rdata(rsp_rdata),
    .bus_ts(bus_ts), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_burst(bus_burst), .bus_bdip(bus_bdip), .bus_rsv_n(bus_rsv_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ta(bus_ta), .bus_bi(bus_bi), .bus_tea(bus_tea)
  );

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int n, input int k);
    return 32'hD000_0000 + 32'(n) * 16 + 32'(k);
  endfunction

  function automatic logic [31:0] rd(input int n, input int k);
    return 32'h5A00_0000 ^ (32'(n) << 8) ^ 32'(k);
  endfunction

  function automatic logic rsv_exp(input logic [3:0] a);
    return !(!a[0] && a[2] && !a[3]);
  endfunction

  // bs: 0 = no inhibit, 1 = inhibit on beat 0, 2 = inhibit on beats 1..3
  // te: beat index carrying the error, 4 = none
  task automatic xfer(input bit wr, input bit bu, input int bs, input int te,
                      input int wt, input int n);
    logic [31:0] base;
    logic [3:0]  at;
    logic [31:0] ea;
    int  k, total;
    bit  fb, fin, more;
    base  = 32'h1000_0000 + 32'(n) * 64;
    at    = 4'(n);
    k     = 0;
    fb    = 1'b0;
    fin   = 1'b0;
    total = bu ? 4 : 1;
    ea    = base;
    req_write = wr;
    req_burst = bu;
    req_addr  = base;
    req_attr  = at;
    for (int i = 0; i < 4; i++) req_wdata[i*32 +: 32] = wd(n, i);
    req_valid = 1'b1;
    chk_eq("R1 ready while idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin) begin
      ea = (bu && !fb) ? base : base + 32'(k) * 4;
      chk_eq("R2 address strobe", 32'(bus_ts), 32'd1);
      chk_eq("R6 address phase address", bus_addr, ea);
      chk_eq("R2 burst flag", 32'(bus_burst), 32'(bu && !fb));
      chk_eq("R2 direction", 32'(bus_write), 32'(wr));
      chk_eq("R3 reservation strobe", 32'(bus_rsv_n), 32'(rsv_exp(at)));
      chk_eq("R1 ready low while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
      more = 1'b1;
      while (more) begin
        for (int w = 0; w < wt; w++) begin
          chk_eq("R9 address held in wait", bus_addr, ea);
          if (wr) chk_eq("R9 write data held in wait", bus_wdata, wd(n, k));
          @(negedge clk);
        end
        chk_eq("R9 address at termination", bus_addr, ea);
        chk_eq("R4 continuation strobe", 32'(bus_bdip), 32'(bu && !fb && k < 3));
        chk_eq("R2 no strobe in data", 32'(bus_ts), 32'd0);
        if (wr) chk_eq("R11 write beat data", bus_wdata, wd(n, k));
        bus_ta    = 1'b1;
        bus_rdata = rd(n, k);
        bus_bi    = (bs == 1 && k == 0) || (bs == 2 && k > 0);
        bus_tea   = (te == k);
        @(negedge clk);
        bus_ta  = 1'b0;
        bus_bi  = 1'b0;
        bus_tea = 1'b0;
        if (te == k) begin
          chk_eq("R8 done on error", 32'(rsp_done), 32'd1);
          chk_eq("R8 error flag", 32'(rsp_err), 32'd1);
          chk_eq("R8 no read beat on error", 32'(rsp_rvalid), 32'd0);
          chk_eq("R8 idle after error", 32'(req_ready), 32'd1);
          fin  = 1'b1;
          more = 1'b0;
        end else begin
          if (!wr) begin
            chk_eq("R5 read beat valid", 32'(rsp_rvalid), 32'd1);
            chk_eq("R5 read beat data", rsp_rdata, rd(n, k));
          end else begin
            chk_eq("R5 no read beat on write", 32'(rsp_rvalid), 32'd0);
          end
          k++;
          if (bu && !fb && k == 1 && bs == 1) fb = 1'b1;
          if (k == total) begin
            chk_eq("R10 done after last beat", 32'(rsp_done), 32'd1);
            chk_eq("R10 no error", 32'(rsp_err), 32'd0);
            if (!bu && bs == 1) chk_eq("R7 inhibit ignored on single", 32'(req_ready), 32'd1);
            fin  = 1'b1;
            more = 1'b0;
          end else begin
            chk_eq("R10 no early done", 32'(rsp_done), 32'd0);
            if (bu && !fb) begin
              chk_eq("R7 burst continues without address phase", 32'(bus_ts), 32'd0);
            end else begin
              chk_eq("R6 new single address phase", 32'(bus_ts), 32'd1);
              more = 1'b0;
            end
          end
        end
      end
    end
    @(negedge clk);
    chk_eq("R10 done is one cycle", 32'(rsp_done), 32'd0);
    chk_eq("R3 strobe high when idle", 32'(bus_rsv_n), 32'd1);
    chk_eq("R5 read valid is one cycle", 32'(rsp_rvalid), 32'd0);
  endtask

  initial begin
    int n;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_burst = 1'b0;
    req_addr  = '0;
    req_attr  = '0;
    req_wdata = '0;
    bus_rdata = '0;
    bus_ta    = 1'b0;
    bus_bi    = 1'b0;
    bus_tea   = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 reset ready", 32'(req_ready), 32'd1);
    chk_eq("R2 reset strobe", 32'(bus_ts), 32'd0);
    chk_eq("R3 reset reservation", 32'(bus_rsv_n), 32'd1);
    chk_eq("R4 reset continuation", 32'(bus_bdip), 32'd0);
    chk_eq("R10 reset done", 32'(rsp_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int bu = 0; bu < 2; bu++)
        for (int bs = 0; bs < 3; bs++)
          for (int te = 0; te < 5; te++)
            for (int wt = 0; wt < 2; wt++) begin
              xfer(wr[0], bu[0], bs, te, wt, n);
              n++;
            end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule